// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host and an asynchronous extended-data-out DRAM with a multiplexed address bus. The host presents one read or write at a time on a valid/ready handshake, carrying a flat word address. The controller splits that address into a row part and a column part. It drives the row on the falling edge of the row strobe and the column on the falling edge of the column strobe. It also sequences the write-enable and output-enable strobes and the direction of the data bus.

A row stays open after an access. A later request to the same row costs only a new column-strobe cycle. A request to another row, a pending refresh request, or a row held open near its maximum low time closes the row and waits out the precharge first. Every analog interval is a parameter counted in system clocks. Writes are always early writes, so the memory never drives the bus during them. Read data is sampled at the end of the column-strobe high phase, while the memory still holds it.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row is taken from the upper ROW_W bits of the request address and presented while the row strobe falls. The column is taken from the lower COL_W bits and presented while the column strobe falls.
- R2: A read returns the data most recently written to the same address. It is sampled on the last clock of the column-strobe high phase and delivered with a one-cycle pulse on rsp_valid_o.
- R3: The row strobe stays low for at least T_RAS cycles. It stays high for at least T_RP cycles before it falls again.
- R4: The column strobe falls only while the row strobe is low. Its first fall comes at least T_RCD cycles after the row strobe falls. Each low phase lasts at least T_CAS cycles, and each high phase before a page access lasts at least T_CP cycles.
- R5: A request whose row equals the open row is served without a new row-strobe cycle.
- R6: A request to a different row closes the open row, precharges, and opens the new row before the column access.
- R7: For a write, the write strobe is low at least one cycle before the column strobe falls and stays low through the column-low phase. The controller drives the data bus for that period and keeps the output enable high.
- R8: For a read, the write strobe stays high, the output enable is low, and the controller does not drive the data bus.
- R9: The row strobe is never held low for more than T_RASP cycles. An open row closes by itself even with no traffic.
- R10: While ref_req_i is high, no request is accepted, the open row is closed, and ref_gnt_o is raised only once the row strobe is high and the precharge time has elapsed.
- R11: After reset, all four strobes are high, the data bus is not driven, no response is pending and the controller is ready.
- R12: Each accepted read produces exactly one response pulse, and a write produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W (20) | Word address, row in the upper bits |
| req_wdata_i | input | DATA_W (4) | Write data |
| rsp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata_o | output | DATA_W (4) | Read data |
| ref_req_i | input | 1 | Refresh arbitration request |
| ref_gnt_o | output | 1 | Row closed and precharged, refresh may proceed |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) (10) | Multiplexed address |
| dram_dq_i | input | DATA_W (4) | Data from the memory |
| dram_dq_o | output | DATA_W (4) | Data to the memory |
| dram_dq_oe_o | output | 1 | Controller drives the data bus |

## Verification
The bench uses a small 8-row by 8-column configuration and covers every address with four sweeps. A row-major write and a row-major read test page hits. A column-major read and a column-major write make every access a row miss. Comparing the number of row-strobe falls in each sweep separates correct row-hit reuse from needless reopening or wrong reuse. A behavioural memory stores data at the decoded row and column and times every strobe edge, so a swapped or shifted address field shows up as wrong read-back data. A long run of same-row reads and an idle wait cover the open-row time limit. A refresh request held during a pending hit checks that arbitration blocks the access and closes the row.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // row closed, precharged
    ST_ACT  = 3'd1,  // row strobe low, waiting row-to-column delay
    ST_CSET = 3'd2,  // column and write strobe set up, column strobe high
    ST_CLO  = 3'd3,  // column strobe low
    ST_CHI  = 3'd4,  // column strobe high, read data held
    ST_OPEN = 3'd5,  // row open, waiting for the next decision
    ST_PRE  = 3'd6   // row strobe high, precharging
  } edo_state_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/edo_delay.sv
module edo_delay #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/edo_row_age.sv
module edo_row_age #(
  parameter int T_RAS  = 4,
  parameter int T_RASP = 10000,
  parameter int T_CAS  = 1,
  parameter int T_CP   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_low_i,
  output logic min_met_o,
  output logic expired_o
);

  localparam int AW  = $clog2(T_RASP + 1);
  // last age at which one more page access still ends inside T_RASP
  localparam int LIM = T_RASP - T_CAS - T_CP - 3;

  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        age_q <= '0;
    else if (!ras_low_i)                age_q <= '0;
    else if (age_q != AW'(T_RASP))      age_q <= age_q + 1'b1;
  end

  assign min_met_o = (age_q >= AW'(T_RAS - 1));
  assign expired_o = (age_q >  AW'(LIM));

  a_r9_rasp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_i |-> (age_q < AW'(T_RASP)));

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              close_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              hit_o
);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      open_q <= 1'b0;
    end else if (load_i) begin
      row_q  <= addr_i[ADDR_W-1:COL_W];
      col_q  <= addr_i[COL_W-1:0];
      open_q <= 1'b1;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;
  assign hit_o = open_q && (addr_i[ADDR_W-1:COL_W] == row_q);

  a_r5_hit_keeps_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && hit_o) |=> $stable(row_o));

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 1,
  parameter int T_CP   = 1,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 4,
  parameter int T_RASP = 10000,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              ref_req_i,
  output logic              ref_gnt_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic              dram_oe_n_o,
  output logic [MUX_W-1:0]  dram_addr_o,
  input  logic [DATA_W-1:0] dram_dq_i,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o
);

  localparam int TMAX = max_of4(T_RCD, T_CAS, T_CP, T_RP);
  localparam int TW   = $clog2(TMAX + 1);

  edo_state_e        st_q, st_d;
  logic              timer_done, timer_load;
  logic [TW-1:0]     tval;
  logic              age_min, age_exp;
  logic              hit, accept, close_req, ras_low, col_phase;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;

  assign req_ready_o = !ref_req_i &&
                       ((st_q == ST_IDLE) || (st_q == ST_OPEN && hit && !age_exp));
  assign accept      = req_valid_i && req_ready_o;
  assign close_req   = ref_req_i || age_exp || (req_valid_i && !hit);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)     st_d = ST_ACT;
      ST_ACT:  if (timer_done) st_d = ST_CSET;
      ST_CSET:                 st_d = ST_CLO;
      ST_CLO:  if (timer_done) st_d = ST_CHI;
      ST_CHI:  if (timer_done) st_d = ST_OPEN;
      ST_OPEN: if (accept)                      st_d = ST_CSET;
               else if (close_req && age_min)   st_d = ST_PRE;
      ST_PRE:  if (timer_done) st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_ACT:  tval = TW'(T_RCD - 1);
      ST_CLO:  tval = TW'(T_CAS - 1);
      ST_CHI:  tval = TW'(T_CP - 1);
      ST_PRE:  tval = TW'(T_RP - 1);
      default: tval = '0;
    endcase
  end

  assign timer_load = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      we_q <= 1'b0;
      wd_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        we_q <= req_we_i;
        wd_q <= req_wdata_i;
      end
    end
  end

  // EDO: data stays valid until the next column fall, so sample late
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= (st_q == ST_CHI) && timer_done && !we_q;
      if ((st_q == ST_CHI) && timer_done && !we_q) rsp_rdata_o <= dram_dq_i;
    end
  end

  edo_delay #(.W(TW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (timer_load),
    .val_i  (tval),
    .done_o (timer_done)
  );

  edo_row_age #(
    .T_RAS (T_RAS),
    .T_RASP(T_RASP),
    .T_CAS (T_CAS),
    .T_CP  (T_CP)
  ) u_age (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_low_i (ras_low),
    .min_met_o (age_min),
    .expired_o (age_exp)
  );

  edo_row_track #(.ROW_W(ROW_W), .COL_W(COL_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .close_i (st_q == ST_PRE),
    .addr_i  (req_addr_i),
    .row_o   (row_q),
    .col_o   (col_q),
    .hit_o   (hit)
  );

  assign ras_low      = !(st_q == ST_IDLE || st_q == ST_PRE);
  assign col_phase    = (st_q == ST_CSET) || (st_q == ST_CLO);
  assign dram_ras_n_o = !ras_low;
  assign dram_cas_n_o = (st_q != ST_CLO);
  assign dram_we_n_o  = !(we_q && col_phase);
  assign dram_oe_n_o  = !(!we_q && (col_phase || st_q == ST_CHI));
  assign dram_dq_oe_o = we_q && col_phase;
  assign dram_dq_o    = wd_q;
  assign dram_addr_o  = (st_q == ST_IDLE || st_q == ST_ACT || st_q == ST_PRE) ?
                        MUX_W'(row_q) : MUX_W'(col_q);
  assign ref_gnt_o    = (st_q == ST_IDLE) && ref_req_i;

  a_r4_cas_under_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_n_o |-> !dram_ras_n_o);

  a_r7_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_n_o) && !dram_we_n_o) |-> $past(!dram_we_n_o));

  a_r8_read_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_n_o |-> (!dram_dq_oe_o && dram_we_n_o));

  a_r10_gnt_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (dram_ras_n_o && !req_ready_o));

  a_r3_ras_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_n_o) |-> $past(age_min));

endmodule

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;

  localparam int ROW_W = 3, COL_W = 3, DATA_W = 4;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_RAS = 6, T_RASP = 60;
  localparam int NW = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [5:0]        req_addr = '0;
  logic [3:0]        req_wdata = '0;
  logic              req_ready, rsp_valid, ref_gnt;
  logic [3:0]        rsp_rdata;
  logic              ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [2:0]        maddr;
  logic [3:0]        dq_o;
  logic [3:0]        mdq = '0;

  edo_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RASP(T_RASP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
    .dram_oe_n_o(oe_n), .dram_addr_o(maddr),
    .dram_dq_i(mdq), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural memory with timing checks, sampled mid-cycle
  logic [3:0] mem [NW];
  int  ras_hi = 100, ras_lo = 0, cas_hi = 100, cas_lo = 0, rasfalls = 0, rsp_cnt = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [2:0] row_l = '0;
  bit first_cas = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        chk(ras_hi >= T_RP, "R3 precharge before row open", ras_hi, T_RP);
        chk(cas_n == 1'b1, "R4 column high at row open", int'(cas_n), 1);
        row_l = maddr; rasfalls++; ras_lo = 0; first_cas = 1'b1;
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo >= T_RAS, "R3 row low time", ras_lo, T_RAS);
        chk(ras_lo <= T_RASP, "R9 row low limit", ras_lo, T_RASP);
        ras_hi = 0; mdq = 'x;
      end
      if (p_cas && !cas_n) begin
        chk(!ras_n, "R4 column under row", int'(ras_n), 0);
        if (first_cas) chk(ras_lo >= T_RCD, "R4 row to column delay", ras_lo, T_RCD);
        else           chk(cas_hi >= T_CP, "R4 column precharge", cas_hi, T_CP);
        first_cas = 1'b0;
        if (!we_n) begin
          chk(!p_we, "R7 write strobe setup", int'(p_we), 0);
          chk(dq_oe && oe_n, "R7 bus driven, output off", int'({dq_oe, oe_n}), 3);
          mem[{row_l, maddr}] = dq_o;
        end else begin
          chk(!dq_oe, "R8 bus released on read", int'(dq_oe), 0);
          mdq = mem[{row_l, maddr}];
        end
        cas_lo = 0;
      end
      if (!p_cas && cas_n) begin
        chk(cas_lo >= T_CAS, "R4 column low time", cas_lo, T_CAS);
        chk(!(!p_we && we_n) || 1'b1, "R7", 0, 0);
        cas_hi = 0;
      end
      if (!cas_n) chk(we_n == p_we || cas_lo == 0, "R7 write strobe held", int'(we_n), int'(p_we));
      if (!oe_n) chk(we_n, "R8 write strobe high on read", int'(we_n), 1);
      if (ras_n) ras_hi++; else ras_lo++;
      if (cas_n) cas_hi++; else cas_lo++;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
      if (rsp_valid) rsp_cnt++;
    end
  end

  logic [3:0] expm [NW];

  function automatic logic [3:0] pat1(int a); return 4'((a * 5 + 3) & 15); endfunction
  function automatic logic [3:0] pat2(int a); return 4'((a * 7 + 11 + (a >> 3)) & 15); endfunction

  task automatic nstep();
    @(negedge clk); #2;
  endtask

  task automatic access(input bit we, input int a, input logic [3:0] d);
    bit got;
    req_valid = 1'b1; req_we = we; req_addr = 6'(a); req_wdata = d;
    forever begin
      #1;
      if (req_ready) begin @(posedge clk); break; end
      nstep();
    end
    nstep();
    req_valid = 1'b0;
    if (we) expm[a] = d;
    else begin
      got = 1'b0;
      for (int i = 0; i < 40 && !got; i++) begin
        if (rsp_valid) got = 1'b1; else nstep();
      end
      chk(got, "R12 read response", int'(got), 1);
      chk(rsp_rdata === expm[a], $sformatf("R2 R1 read data addr %0d", a),
          int'(rsp_rdata), int'(expm[a]));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual expired expected completion");
    summary();
    $finish;
  end

  initial begin
    int b, rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nstep();
    // R11 reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R11 strobes idle", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk(!dq_oe && !rsp_valid, "R11 bus and response idle", int'({dq_oe, rsp_valid}), 0);
    chk(req_ready, "R11 ready", int'(req_ready), 1);

    // row-major writes: one row open per row (R5)
    b = rasfalls; rc = rsp_cnt;
    for (int a = 0; a < NW; a++) access(1'b1, a, pat1(a));
    chk(rasfalls - b == 8, "R5 row-major write row opens", rasfalls - b, 8);
    chk(rsp_cnt == rc, "R12 no response on write", rsp_cnt - rc, 0);

    // column-major reads: every access a miss (R6)
    b = rasfalls; rc = rsp_cnt;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) access(1'b0, r * 8 + c, 4'h0);
    chk(rasfalls - b == 64, "R6 column-major read row opens", rasfalls - b, 64);
    chk(rsp_cnt - rc == 64, "R12 one response per read", rsp_cnt - rc, 64);

    // column-major writes, then row-major reads
    b = rasfalls;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) access(1'b1, r * 8 + c, pat2(r * 8 + c));
    chk(rasfalls - b == 64, "R6 column-major write row opens", rasfalls - b, 64);
    b = rasfalls;
    for (int a = 0; a < NW; a++) access(1'b0, a, 4'h0);
    chk(rasfalls - b == 8, "R5 row-major read row opens", rasfalls - b, 8);

    // R10 refresh arbitration with a pending hit to the open row (row 7)
    ref_req = 1'b1; req_valid = 1'b1; req_we = 1'b1; req_addr = 6'd63; req_wdata = 4'hA;
    rc = 0;
    for (int i = 0; i < 50 && !ref_gnt; i++) begin
      #1; chk(!req_ready, "R10 no accept during refresh", int'(req_ready), 0);
      nstep(); rc++;
    end
    chk(ref_gnt, "R10 grant reached", int'(ref_gnt), 1);
    chk(ras_n && ras_hi >= T_RP, "R10 grant after precharge", ras_hi, T_RP);
    for (int i = 0; i < 4; i++) begin
      nstep();
      chk(ras_n && ref_gnt && !req_ready, "R10 held idle", int'({ras_n, ref_gnt, req_ready}), 6);
    end
    req_valid = 1'b0; ref_req = 1'b0;
    nstep();
    chk(expm[63] == pat2(63), "R10 blocked write had no effect", int'(expm[63]), int'(pat2(63)));
    b = rasfalls;
    access(1'b0, 63, 4'h0);
    chk(rasfalls - b == 1, "R10 row reopened after refresh", rasfalls - b, 1);

    // R9 long run of hits on row 7 must be split by a forced close
    b = rasfalls;
    for (int i = 0; i < 16; i++) access(1'b0, 56 + (i % 8), 4'h0);
    chk(rasfalls - b >= 1, "R9 forced close during hit run", rasfalls - b, 1);

    // alternating rows, mixed writes and reads
    for (int i = 0; i < 8; i++) begin
      access(1'b1, (i % 2) * 40 + i, 4'(i + 9));
      access(1'b0, (i % 2) * 40 + i, 4'h0);
    end

    // R9 idle open row closes by itself
    repeat (T_RASP + 10) nstep();
    chk(ras_n, "R9 idle row closed", int'(ras_n), 1);

    summary();
    $finish;
  end

endmodule